// File: doc/BRIEF.md
# Spawn-Join Thread Dispatch Controller

This block connects a serial master to an array of lightweight thread control units (TCUs). When the master requests a spawn, the block takes the inclusive thread range `[lo, hi]` and the start address of the parallel code. It places them on one shared bus for a single cycle. Every TCU reads the bus in that cycle and takes its first virtual thread ID from its own index. Each TCU then runs its thread. Thread execution is outside this block, so the end of a thread shows up only as a done pulse, which can arrive after any number of cycles. After each thread the TCU fetches a new ID from a shared counter through an atomic fetch-and-add of one. Because TCUs fetch work only when they are free, the load is balanced at run time and no range is split up in advance.

A TCU whose new ID lies above the upper bound stops and goes idle; it never polls. When every TCU is idle, a registered all-idle flag releases the master through a one-cycle join pulse, and a new spawn can then be accepted. Several TCUs can ask for IDs in the same cycle. A prefix-sum over their requests gives each of them a different ID, handed out in ascending TCU index. The TCUs are arranged as clusters of lanes, and both the cluster count and the lane count are parameters.

Master states: IDLE (accepts a spawn) → BCAST (bus valid for one cycle) → WAIT (waits for the registered all-idle flag) → JOIN (join pulse) → IDLE. TCU states: IDLE → RUN on the broadcast if the first ID is in range; RUN → CLAIM on done; CLAIM → RUN if the claimed ID is in range, otherwise CLAIM → IDLE.

Top module: `sj_dispatch`

## Requirements
- R1: A spawn request sampled in master IDLE makes `bcast_valid` high for exactly the next cycle. In that cycle `bcast_lo`, `bcast_hi` and `bcast_pc` carry the requested values.
- R2: While `busy` is high, a spawn request is ignored: no broadcast follows, and the values on the bus stay as they are.
- R3: On the broadcast, TCU i takes ID `lo+i`. It shows `tcu_run` high with that ID from the next cycle if `lo+i <= hi`, and otherwise it stays idle.
- R4: A done pulse in RUN is followed by one CLAIM cycle with `tcu_run` low. The TCU then runs the next ID from the shared counter. The counter starts at `lo + NTCU` and rises by one per grant.
- R5: Requests made in the same CLAIM cycle get consecutive IDs, with lower TCU indices receiving lower IDs.
- R6: A TCU whose claimed ID is greater than `hi` goes idle and gets no more IDs until the next broadcast. The comparison is correct even when `hi` is the largest value an ID field can hold.
- R7: A done pulse on a TCU that is not in RUN has no effect on that TCU.
- R8: `join_done` pulses for one cycle. It rises two cycles after the first cycle in which all TCUs are idle after the broadcast, and `busy` is low in the following cycle.
- R9: If the range is empty (`hi < lo`), no TCU runs and the join still completes.
- R10: Every ID in `[lo, hi]` is run exactly once over a whole spawn.
- R11: During and right after reset, `busy`, `join_done`, `bcast_valid` and all `tcu_run` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_req | input | 1 | Master spawn request |
| spawn_lo | input | ID_W | First thread ID of the range |
| spawn_hi | input | ID_W | Last thread ID of the range (inclusive) |
| spawn_pc | input | PC_W | Start address of the parallel code |
| tcu_done | input | NTCU | Per-TCU thread-finished pulse |
| busy | output | 1 | A spawn is in progress |
| join_done | output | 1 | One-cycle release of the master |
| bcast_valid | output | 1 | Shared broadcast bus valid |
| bcast_lo | output | ID_W | Broadcast lower bound |
| bcast_hi | output | ID_W | Broadcast upper bound |
| bcast_pc | output | PC_W | Broadcast code address |
| tcu_run | output | NTCU | TCU i is executing a thread |
| tcu_tid | output | NTCU*ID_W | Thread ID of TCU i, in bits i*ID_W upward |

## Verification
The assertions take for granted that `tcu_done` pulses only for a TCU that is running. Pulses in other states must be dropped, and the bench checks that at the ports. They also take for granted that the range and the TCU count fit inside one ID bit more than the ID width, so the counter cannot wrap. The stimulus raises done at random on running TCUs, and adds a small share of stray pulses on idle TCUs and TCUs in CLAIM. It also runs phases where every running TCU finishes in the same cycle, which drives the fetch-and-add unit at full width. All ranges fit the ID width, including one that ends at its largest value.

// File: rtl/sj_pkg.sv
package sj_pkg;
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_BCAST = 2'd1,
        M_WAIT  = 2'd2,
        M_JOIN  = 2'd3
    } mst_state_e;

    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_RUN   = 2'd1,
        T_CLAIM = 2'd2
    } tcu_state_e;
endpackage

// File: rtl/sj_spawn_ctl.sv
module sj_spawn_ctl
    import sj_pkg::*;
#(
    parameter int ID_W = 16,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spawn_req,
    input  logic [ID_W-1:0] spawn_lo,
    input  logic [ID_W-1:0] spawn_hi,
    input  logic [PC_W-1:0] spawn_pc,
    input  logic            all_idle,
    output logic            busy,
    output logic            join_done,
    output logic            bcast_valid,
    output logic [ID_W-1:0] bcast_lo,
    output logic [ID_W-1:0] bcast_hi,
    output logic [PC_W-1:0] bcast_pc
);
    mst_state_e      state, state_nx;
    logic            idle_q;
    logic [ID_W-1:0] lo_q, hi_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= M_IDLE;
            idle_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
            pc_q   <= '0;
        end else begin
            state  <= state_nx;
            idle_q <= (state != M_BCAST) && all_idle;
            if (state == M_IDLE && spawn_req) begin
                lo_q <= spawn_lo;
                hi_q <= spawn_hi;
                pc_q <= spawn_pc;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            M_IDLE:  if (spawn_req) state_nx = M_BCAST;
            M_BCAST: state_nx = M_WAIT;
            M_WAIT:  if (idle_q) state_nx = M_JOIN;
            M_JOIN:  state_nx = M_IDLE;
            default: state_nx = M_IDLE;
        endcase
    end

    always_comb begin
        busy        = (state != M_IDLE);
        join_done   = (state == M_JOIN);
        bcast_valid = (state == M_BCAST);
        bcast_lo    = lo_q;
        bcast_hi    = hi_q;
        bcast_pc    = pc_q;
    end

    p_bcast_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |=> !bcast_valid);
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && spawn_req) |=> ($stable(lo_q) && $stable(hi_q) && $stable(pc_q)));
    p_join_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |=> !busy);
    p_join_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |-> all_idle);
endmodule

// File: rtl/sj_id_alloc.sv
module sj_id_alloc #(
    parameter int NTCU = 64,
    parameter int ID_W = 16,
    localparam int EW = ID_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ID_W-1:0]  lo,
    input  logic [NTCU-1:0]  req,
    output logic [NTCU*EW-1:0] grant
);
    logic [EW-1:0] ctr;
    logic [EW-1:0] total;

    // prefix sum over requests: lower index gets the lower ID
    always_comb begin
        logic [EW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NTCU; i++) begin
            grant[i*EW +: EW] = ctr + acc;
            acc = acc + EW'(req[i]);
        end
        total = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctr <= '0;
        else if (load) ctr <= {1'b0, lo} + EW'(NTCU);
        else           ctr <= ctr + total;
    end

    p_ctr_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!load) && !load |-> ctr >= $past(ctr));
endmodule

// File: rtl/sj_tcu_fsm.sv
module sj_tcu_fsm
    import sj_pkg::*;
#(
    parameter int ID_W = 16,
    parameter int IDX  = 0,
    localparam int EW = ID_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ID_W-1:0] lo,
    input  logic [ID_W-1:0] hi,
    input  logic            done,
    input  logic [EW-1:0]   grant,
    output logic            req,
    output logic            run,
    output logic            idle,
    output logic [ID_W-1:0] tid
);
    tcu_state_e    state, state_nx;
    logic [EW-1:0] first_id, hi_e;

    assign first_id = {1'b0, lo} + EW'(IDX);
    assign hi_e     = {1'b0, hi};

    always_comb begin
        state_nx = state;
        unique case (state)
            T_IDLE:  if (load) state_nx = (first_id <= hi_e) ? T_RUN : T_IDLE;
            T_RUN:   if (done) state_nx = T_CLAIM;
            T_CLAIM: state_nx = (grant <= hi_e) ? T_RUN : T_IDLE;
            default: state_nx = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            tid   <= '0;
        end else begin
            state <= state_nx;
            if (state == T_IDLE && load) tid <= first_id[ID_W-1:0];
            else if (state == T_CLAIM)   tid <= grant[ID_W-1:0];
        end
    end

    always_comb begin
        req  = (state == T_CLAIM);
        run  = (state == T_RUN);
        idle = (state == T_IDLE);
    end

    p_claim_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> tid <= hi);
    p_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !load) |=> idle);
endmodule

// File: rtl/sj_dispatch.sv
module sj_dispatch #(
    parameter int N_CLUST   = 4,
    parameter int LANES     = 16,
    parameter int ID_W      = 16,
    parameter int PC_W      = 32,
    localparam int NTCU = N_CLUST * LANES,
    localparam int EW   = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spawn_req,
    input  logic [ID_W-1:0]   spawn_lo,
    input  logic [ID_W-1:0]   spawn_hi,
    input  logic [PC_W-1:0]   spawn_pc,
    input  logic [NTCU-1:0]   tcu_done,
    output logic              busy,
    output logic              join_done,
    output logic              bcast_valid,
    output logic [ID_W-1:0]   bcast_lo,
    output logic [ID_W-1:0]   bcast_hi,
    output logic [PC_W-1:0]   bcast_pc,
    output logic [NTCU-1:0]   tcu_run,
    output logic [NTCU*ID_W-1:0] tcu_tid
);
    logic [NTCU-1:0]    claim_req;
    logic [NTCU-1:0]    tcu_idle;
    logic [NTCU*EW-1:0] grant;

    sj_spawn_ctl #(.ID_W(ID_W), .PC_W(PC_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .spawn_req(spawn_req), .spawn_lo(spawn_lo), .spawn_hi(spawn_hi), .spawn_pc(spawn_pc),
        .all_idle(&tcu_idle),
        .busy(busy), .join_done(join_done), .bcast_valid(bcast_valid),
        .bcast_lo(bcast_lo), .bcast_hi(bcast_hi), .bcast_pc(bcast_pc)
    );

    sj_id_alloc #(.NTCU(NTCU), .ID_W(ID_W)) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .load(bcast_valid), .lo(bcast_lo), .req(claim_req), .grant(grant)
    );

    for (genvar c = 0; c < N_CLUST; c++) begin : g_clust
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int IX = c * LANES + l;
            sj_tcu_fsm #(.ID_W(ID_W), .IDX(IX)) u_tcu (
                .clk(clk), .rst_n(rst_n),
                .load(bcast_valid), .lo(bcast_lo), .hi(bcast_hi),
                .done(tcu_done[IX]), .grant(grant[IX*EW +: EW]),
                .req(claim_req[IX]), .run(tcu_run[IX]), .idle(tcu_idle[IX]),
                .tid(tcu_tid[IX*ID_W +: ID_W])
            );
        end
    end
endmodule

// File: tb/sj_dispatch_tb.sv
module sj_dispatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCL = 2;
    localparam int NLN = 4;
    localparam int NT  = NCL * NLN;
    localparam int IW  = 8;
    localparam int PW  = 16;
    localparam int WATCHDOG = 150000;

    logic clk = 0;
    logic rst_n = 0;
    logic spawn_req = 0;
    logic [IW-1:0] spawn_lo = 0, spawn_hi = 0;
    logic [PW-1:0] spawn_pc = 0;
    logic [NT-1:0] tcu_done = 0;
    logic busy, join_done, bcast_valid;
    logic [IW-1:0] bcast_lo, bcast_hi;
    logic [PW-1:0] bcast_pc;
    logic [NT-1:0] tcu_run;
    logic [NT*IW-1:0] tcu_tid;

    sj_dispatch #(.N_CLUST(NCL), .LANES(NLN), .ID_W(IW), .PC_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_lo(spawn_lo),
        .spawn_hi(spawn_hi), .spawn_pc(spawn_pc), .tcu_done(tcu_done),
        .busy(busy), .join_done(join_done), .bcast_valid(bcast_valid),
        .bcast_lo(bcast_lo), .bcast_hi(bcast_hi), .bcast_pc(bcast_pc),
        .tcu_run(tcu_run), .tcu_tid(tcu_tid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state: master 0 idle,1 bcast,2 wait,3 join; tcu 0 idle,1 run,2 claim
    int m_st = 0, m_allq = 0, m_lo = 0, m_hi = 0, m_pc = 0, m_ctr = 0;
    int t_st[NT];
    int t_id[NT];
    int seen[256];
    int o_st, o_allq, all_idle, k, base, nid;
    int vec = 0, bad = 0, cyc = 0, mode = 0, joins = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input int got, input int exp);
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_allq = 0; m_ctr = 0;
            for (int i = 0; i < NT; i++) begin t_st[i] = 0; t_id[i] = 0; end
        end else begin
            o_st = m_st; o_allq = m_allq; all_idle = 1;
            for (int i = 0; i < NT; i++) if (t_st[i] != 0) all_idle = 0;
            base = m_ctr; k = 0;
            if (o_st == 1) begin
                for (int i = 0; i < NT; i++) begin
                    nid = m_lo + i; t_id[i] = nid;
                    if (nid <= m_hi) begin t_st[i] = 1; seen[nid]++; end else t_st[i] = 0;
                end
                m_ctr = m_lo + NT;
            end else begin
                for (int i = 0; i < NT; i++) begin
                    if (t_st[i] == 1) begin
                        if (tcu_done[i]) t_st[i] = 2;
                    end else if (t_st[i] == 2) begin
                        nid = base + k; k++;
                        if (nid <= m_hi) begin t_st[i] = 1; t_id[i] = nid; seen[nid]++; end
                        else t_st[i] = 0;
                    end
                end
                m_ctr = base + k;
            end
            m_allq = (o_st != 1) && all_idle;
            case (o_st)
                0: if (spawn_req) begin
                       m_lo = spawn_lo; m_hi = spawn_hi; m_pc = spawn_pc; m_st = 1;
                       for (int j = 0; j < 256; j++) seen[j] = 0;
                   end
                1: m_st = 2;
                2: if (o_allq) m_st = 3;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        vec++;
        chk("R2 busy", busy, m_st != 0);
        chk("R8 join_done", join_done, m_st == 3);
        chk("R1 bcast_valid", bcast_valid, m_st == 1);
        if (join_done) joins++;
        if (m_st == 1) begin
            chk("R1 bcast_lo", bcast_lo, m_lo);
            chk("R1 bcast_hi", bcast_hi, m_hi);
            chk("R1 bcast_pc", bcast_pc, m_pc);
        end
        for (int i = 0; i < NT; i++) begin
            // run bit covers R3 start, R6 retirement and R7 stray done
            chk("R3/R6/R7 tcu_run", tcu_run[i], t_st[i] == 1);
            if (t_st[i] == 1) chk("R4/R5 tcu_tid", tcu_tid[i*IW +: IW], t_id[i]);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int i = 0; i < NT; i++) begin
            if (mode == 1) tcu_done[i] = (t_st[i] == 1);
            else if (t_st[i] == 1) tcu_done[i] = (lfsr[i] ^ lfsr[i+5]) & lfsr[i+2];
            else tcu_done[i] = lfsr[15] & lfsr[3] & lfsr[i+1];
        end
        if (cyc > WATCHDOG) begin
            bad++;
            $display("FAIL R8 watchdog: actual hung expected join");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic spawn(input int lo, input int hi, input int pc);
        @(negedge clk);
        spawn_req = 1; spawn_lo = IW'(lo); spawn_hi = IW'(hi); spawn_pc = PW'(pc);
        @(negedge clk);
        spawn_req = 0;
    endtask

    task automatic finish_spawn(input int lo, input int hi);
        int j0 = joins;
        while (m_st != 0) @(negedge clk);
        chk("R8 join pulse count", joins - j0, 1);
        for (int id = lo; id <= hi; id++) chk("R10 id run once", seen[id], 1);
        if (hi < lo) for (int id = 0; id < 256; id++) chk("R9 no thread run", seen[id], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 busy", busy, 0);
        chk("R11 join_done", join_done, 0);
        chk("R11 bcast_valid", bcast_valid, 0);
        chk("R11 tcu_run", tcu_run, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        mode = 0;
        spawn(0, 40, 'h1000);
        repeat (6) @(negedge clk);
        // R2: requests while busy must not reach the bus
        spawn_req = 1; spawn_lo = 8'd99; spawn_hi = 8'd120; spawn_pc = 16'hBEEF;
        repeat (3) @(negedge clk);
        spawn_req = 0;
        chk("R2 bus lo held", bcast_lo, 0);
        chk("R2 bus pc held", bcast_pc, 'h1000);
        finish_spawn(0, 40);

        spawn(10, 5, 'h2000);          // R9 empty range
        finish_spawn(10, 5);

        spawn(3, 5, 'h2400);           // R3 fewer threads than TCUs
        finish_spawn(3, 5);

        spawn(0, 0, 'h2800);
        finish_spawn(0, 0);

        mode = 1;                      // R5 all TCUs claim together
        spawn(2, 60, 'h3000);
        finish_spawn(2, 60);

        mode = 0;
        spawn(250, 255, 'h3400);       // R6 range ends at ID field maximum
        finish_spawn(250, 255);

        mode = 1;
        spawn(200, 255, 'h3800);
        finish_spawn(200, 255);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule